// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block drives the command, bank and address pins of a double-data-rate graphics DRAM from the controller side during power-up, until the device is ready for normal traffic. After reset it holds clock enable low for a programmable clock-stable interval. It then issues a NOP with clock enable raised, followed by a fixed series of commands. Each command is followed by the minimum gap that command requires.

The series is as follows. A precharge of all banks. An extended mode write that enables the on-die DLL and sets drive strength. A mode write that sets the DLL-reset bit. A second precharge of all banks. A programmable number of auto-refreshes. A final mode write with the DLL-reset bit clear. Burst length, burst type, CAS latency code and drive strength come from parameters, and so does every wait count. The block enforces the DLL lock interval, counted from the DLL-reset write. When the last gap and the lock interval have both run out, it pulses a done flag for one cycle and then holds NOP with clock enable high until the next reset.

Top module: `dram_init_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, the pins hold NOP. NOP is the four-bit value {cs_n,ras_n,cas_n,we_n} = 0111, with `ba` = 0, `addr` = 0, `cke` = 0 and `init_done` = 0.
- R2: Counting rising edges from reset release, `cke` stays low through edge T_STABLE and first goes high after edge T_STABLE+1, on a NOP. After that it never falls.
- R3: The only non-NOP commands are these, in this order: precharge-all, extended mode write, DLL-reset mode write, precharge-all, N_REF auto-refreshes and a final mode write. Every other cycle is NOP, and every command is issued with `cke` high. The encodings of {cs_n,ras_n,cas_n,we_n} are: precharge 0010, refresh 0001, mode and extended mode write 0000. A refresh drives `ba` = 0 and `addr` = 0.
- R4: The first precharge comes T_CKE edges after `cke` rises. The next command follows a precharge after T_RP edges, a mode write after T_MRD edges and a refresh after T_RFC edges.
- R5: A precharge-all drives `ba` = 0 and sets only address bit AP_BIT, which is 8 by default.
- R6: The extended mode write drives `ba` = 01 (bank bit 0 high). Its address has bit 0 = 0 (DLL enabled), bit 1 = DRV[0], bit 6 = DRV[1], and all other bits 0.
- R7: Both mode writes drive `ba` = 00. Their address bits are: [2:0] = MODE_BL, [3] = MODE_BT, [6:4] = MODE_CL, [7] = 0, [8] = 1 for the DLL-reset write and 0 for the final write, and the bits above 8 are 0.
- R8: `init_done` is high for exactly one cycle. That cycle comes at the later of two edges: T_MRD edges after the final mode write, or T_DLL edges after the DLL-reset write. It does not rise again before the next reset.
- R9: After the done pulse the pins hold NOP with `cke` high.
- R10: A reset asserted at any point of the sequence returns the pins to the R1 state, and the full sequence then restarts from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | Clock enable to the DRAM |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Row/mode address |
| init_done | output | 1 | One-cycle pulse when initialization is complete |

## Verification
The hardest state to reach from the ports is a reset that lands in the middle of a wait. Such a reset could leave a stale gap count, a partly counted DLL lock interval or a refresh count behind. The bench therefore aborts runs with a reset at random edges drawn from a seeded generator, plus directed edges: the first edge, the edge just after the DLL-reset write, and the done edge. After each abort it requires a complete, correctly timed sequence. The bench parameters put the DLL lock interval one cycle past the final mode-write gap, so the done edge depends on the lock wait and not on the last gap.

// File: rtl/dinit_pkg.sv
package dinit_pkg;

    typedef enum logic [3:0] {
        ST_PWR, ST_CKE, ST_PRE1, ST_EMRS, ST_MRS_DLL,
        ST_PRE2, ST_REF, ST_MRS_FIN, ST_WAIT_DONE, ST_IDLE
    } step_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_t;

    localparam cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam cmd_t CMD_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // main mode word: length, type, latency, test bit held 0, DLL reset
    function automatic logic [15:0] mode_word(input logic [2:0] bl, input logic bt,
                                              input logic [2:0] cl, input logic dll_rst);
        return {7'b0, dll_rst, 1'b0, cl, bt, bl};
    endfunction

    // extended word: bit 0 low keeps the DLL on, drive strength on bits 6 and 1
    function automatic logic [15:0] emode_word(input logic [1:0] drv);
        logic [15:0] w;
        w    = '0;
        w[6] = drv[1];
        w[1] = drv[0];
        return w;
    endfunction

    function automatic logic [15:0] prea_word(input int ap_bit);
        logic [15:0] w;
        w         = '0;
        w[ap_bit] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/dinit_gap_timer.sv
module dinit_gap_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (!expired)
            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/dinit_dll_wait.sv
module dinit_dll_wait #(
    parameter int T_DLL = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic ready
);
    localparam int DW = $clog2(T_DLL + 1);

    logic [DW-1:0] cnt_q;
    logic          armed_q;

    assign ready = armed_q && (cnt_q == DW'(T_DLL));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (start) begin
            cnt_q   <= DW'(1);
            armed_q <= 1'b1;
        end else if (armed_q && (cnt_q != DW'(T_DLL))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
    import dinit_pkg::*;
#(
    parameter int         ADDR_W   = 12,
    parameter int         BA_W     = 2,
    parameter int         T_STABLE = 20000,
    parameter int         T_CKE    = 2,
    parameter int         T_RP     = 7,
    parameter int         T_MRD    = 4,
    parameter int         T_RFC    = 25,
    parameter int         T_DLL    = 200,
    parameter int         N_REF    = 2,
    parameter int         AP_BIT   = 8,
    parameter logic [2:0] MODE_BL  = 3'b010,
    parameter logic       MODE_BT  = 1'b0,
    parameter logic [2:0] MODE_CL  = 3'b101,
    parameter logic [1:0] DRV      = 2'b00
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);
    localparam int T_MAX = imax(imax(imax(T_STABLE, T_RFC), imax(T_RP, T_MRD)), T_CKE);
    localparam int CNT_W = $clog2(T_MAX + 1);
    localparam int REF_W = $clog2(N_REF + 1);

    step_e             step_q, nxt_step;
    logic [REF_W-1:0]  ref_q;
    cmd_t              cmd_q, nxt_cmd;
    logic [BA_W-1:0]   ba_q, nxt_ba;
    logic [ADDR_W-1:0] addr_q, nxt_addr;
    logic              cke_q, nxt_cke;
    logic              done_q, done_now;
    logic              fire, dll_start, gap_expired, dll_ready;
    int                gap;

    dinit_gap_timer #(.CNT_W(CNT_W)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .load     (fire),
        .load_val (CNT_W'(gap - 1)),
        .expired  (gap_expired)
    );

    dinit_dll_wait #(.T_DLL(T_DLL)) u_dll (
        .clk   (clk),
        .rst   (rst),
        .start (fire && dll_start),
        .ready (dll_ready)
    );

    always_comb begin
        nxt_cmd   = CMD_NOP;
        nxt_ba    = '0;
        nxt_addr  = '0;
        nxt_cke   = cke_q;
        nxt_step  = step_q;
        gap       = 1;
        dll_start = 1'b0;
        done_now  = 1'b0;
        fire      = gap_expired;
        case (step_q)
            ST_PWR: begin
                nxt_cke  = 1'b0;
                gap      = T_STABLE;
                nxt_step = ST_CKE;
            end
            ST_CKE: begin
                nxt_cke  = 1'b1;
                gap      = T_CKE;
                nxt_step = ST_PRE1;
            end
            ST_PRE1, ST_PRE2: begin
                nxt_cmd  = CMD_PRE;
                nxt_addr = ADDR_W'(prea_word(AP_BIT));
                gap      = T_RP;
                nxt_step = (step_q == ST_PRE1) ? ST_EMRS : ST_REF;
            end
            ST_EMRS: begin
                nxt_cmd  = CMD_MRS;
                nxt_ba   = BA_W'(1);
                nxt_addr = ADDR_W'(emode_word(DRV));
                gap      = T_MRD;
                nxt_step = ST_MRS_DLL;
            end
            ST_MRS_DLL: begin
                nxt_cmd   = CMD_MRS;
                nxt_addr  = ADDR_W'(mode_word(MODE_BL, MODE_BT, MODE_CL, 1'b1));
                gap       = T_MRD;
                dll_start = 1'b1;
                nxt_step  = ST_PRE2;
            end
            ST_REF: begin
                nxt_cmd  = CMD_REF;
                gap      = T_RFC;
                nxt_step = (ref_q == REF_W'(N_REF - 1)) ? ST_MRS_FIN : ST_REF;
            end
            ST_MRS_FIN: begin
                nxt_cmd  = CMD_MRS;
                nxt_addr = ADDR_W'(mode_word(MODE_BL, MODE_BT, MODE_CL, 1'b0));
                gap      = T_MRD;
                nxt_step = ST_WAIT_DONE;
            end
            ST_WAIT_DONE: begin
                fire     = gap_expired && dll_ready;
                done_now = 1'b1;
                nxt_step = ST_IDLE;
            end
            default: fire = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= ST_PWR;
            ref_q  <= '0;
            cmd_q  <= CMD_NOP;
            ba_q   <= '0;
            addr_q <= '0;
            cke_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= fire && done_now;
            if (fire) begin
                step_q <= nxt_step;
                cmd_q  <= nxt_cmd;
                ba_q   <= nxt_ba;
                addr_q <= nxt_addr;
                cke_q  <= nxt_cke;
                if (step_q == ST_REF)
                    ref_q <= ref_q + 1'b1;
            end else begin
                cmd_q  <= CMD_NOP;
                ba_q   <= '0;
                addr_q <= '0;
            end
        end
    end

    assign cke       = cke_q;
    assign cs_n      = cmd_q.cs_n;
    assign ras_n     = cmd_q.ras_n;
    assign cas_n     = cmd_q.cas_n;
    assign we_n      = cmd_q.we_n;
    assign ba        = ba_q;
    assign addr      = addr_q;
    assign init_done = done_q;
endmodule

// File: rtl/dinit_checker.sv
module dinit_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done
);
    logic [3:0] cmd;
    logic       done_seen;

    assign cmd = {cs_n, ras_n, cas_n, we_n};

    always_ff @(posedge clk) begin
        if (rst)
            done_seen <= 1'b0;
        else if (init_done)
            done_seen <= 1'b1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!cke && !init_done && cmd == 4'b0111));

    a_r2_cke_holds: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    a_r3_cmd_needs_cke: assert property (@(posedge clk) disable iff (rst)
        (cmd != 4'b0111) |-> cke);

    a_r4_cmd_then_nop: assert property (@(posedge clk) disable iff (rst)
        (cmd != 4'b0111) |=> (cmd == 4'b0111));

    a_r7_test_bit_low: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0000) |-> !addr[7]);

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        init_done |=> !init_done);

    a_r8_done_once: assert property (@(posedge clk) disable iff (rst)
        done_seen |-> !init_done);

    a_r9_idle_after_done: assert property (@(posedge clk) disable iff (rst)
        done_seen |-> (cmd == 4'b0111 && cke));
endmodule

bind dram_init_seq dinit_checker #(.ADDR_W(ADDR_W)) u_dinit_chk (
    .clk       (clk),
    .rst       (rst),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .init_done (init_done)
);

// File: tb/test_dram_init_seq.sv
module test_dram_init_seq;
    localparam int         TB_STABLE = 3000;
    localparam int         TB_CKE    = 2;
    localparam int         TB_RP     = 6;
    localparam int         TB_MRD    = 4;
    localparam int         TB_RFC    = 15;
    localparam int         TB_DLL    = 60;
    localparam int         TB_NREF   = 3;
    localparam int         TB_AP     = 8;
    localparam logic [2:0] TB_BL     = 3'b011;
    localparam logic       TB_BT     = 1'b1;
    localparam logic [2:0] TB_CL     = 3'b110;
    localparam logic [1:0] TB_DRV    = 2'b10;
    localparam int         NCMD      = 5 + TB_NREF;
    localparam int         TAIL      = 40;
    localparam logic [17:0] NOP_VEC  = {4'b0111, 14'b0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [1:0]  ba;
    logic [11:0] addr;

    int n_tests = 0;
    int n_fail  = 0;
    int e_at[NCMD];
    int e_cke, e_done;

    always #5 clk = ~clk;

    dram_init_seq #(
        .ADDR_W(12), .BA_W(2), .T_STABLE(TB_STABLE), .T_CKE(TB_CKE), .T_RP(TB_RP),
        .T_MRD(TB_MRD), .T_RFC(TB_RFC), .T_DLL(TB_DLL), .N_REF(TB_NREF), .AP_BIT(TB_AP),
        .MODE_BL(TB_BL), .MODE_BT(TB_BT), .MODE_CL(TB_CL), .DRV(TB_DRV)
    ) i_dram_init_seq (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done)
    );

    function automatic logic [17:0] obs();
        return {cs_n, ras_n, cas_n, we_n, ba, addr};
    endfunction

    function automatic logic [17:0] exp_vec(input int k);
        logic [11:0] mw;
        mw = {3'b000, 1'b0, 1'b0, TB_CL, TB_BT, TB_BL};
        if (k == 0 || k == 3) return {4'b0010, 2'b00, 12'(1 << TB_AP)};
        if (k == 1) return {4'b0000, 2'b01, 12'((int'(TB_DRV[1]) << 6) | (int'(TB_DRV[0]) << 1))};
        if (k == 2) return {4'b0000, 2'b00, mw | 12'h100};
        if (k == NCMD - 1) return {4'b0000, 2'b00, mw};
        return {4'b0001, 2'b00, 12'h000};
    endfunction

    function automatic string req_of(input int k);
        if (k == 0 || k == 3) return "R5";
        if (k == 1) return "R6";
        if (k == 2 || k == NCMD - 1) return "R7";
        return "R3";
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic build_plan();
        e_cke   = TB_STABLE + 1;
        e_at[0] = e_cke + TB_CKE;
        e_at[1] = e_at[0] + TB_RP;
        e_at[2] = e_at[1] + TB_MRD;
        e_at[3] = e_at[2] + TB_MRD;
        e_at[4] = e_at[3] + TB_RP;
        for (int i = 5; i < NCMD; i++) e_at[i] = e_at[i-1] + TB_RFC;
        e_done = e_at[NCMD-1] + TB_MRD;
        if (e_at[2] + TB_DLL > e_done) e_done = e_at[2] + TB_DLL;
    endtask

    task automatic do_reset(input string ctx);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(obs() == NOP_VEC && !cke && !init_done, "R1", {"reset state ", ctx},
            {13'b0, cke, init_done, obs()}, {15'b0, NOP_VEC});
        rst = 1'b0;
    endtask

    task automatic run(input int stop_n, input bit full, input string ctx);
        int kk = 0, stray = 0, first_hi = 0, cke_drop = 0;
        int done_cnt = 0, done_at = 0, idle_bad = 0;
        int last = full ? e_done + TAIL : stop_n;
        for (int n = 1; n <= last; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (cke && first_hi == 0) first_hi = n;
            if (!cke && first_hi != 0) cke_drop++;
            if (kk < NCMD && n == e_at[kk]) begin
                if (full)
                    chk(obs() == exp_vec(kk) && cke, req_of(kk),
                        $sformatf("command %0d %s", kk, ctx), {14'b0, obs()}, {14'b0, exp_vec(kk)});
                kk++;
            end else if (obs() != NOP_VEC) begin
                stray++;
            end
            if (init_done) begin
                done_cnt++;
                done_at = n;
            end
            if (done_at != 0 && n > done_at && (obs() != NOP_VEC || !cke)) idle_bad++;
        end
        if (full) begin
            chk(first_hi == e_cke, "R2", {"cke rise edge ", ctx}, first_hi, e_cke);
            chk(cke_drop == 0, "R2", {"cke fell ", ctx}, cke_drop, 0);
            chk(kk == NCMD && stray == 0, "R4", {"gaps and stray commands (R3) ", ctx}, stray, 0);
            chk(done_cnt == 1, "R8", {"done pulse count ", ctx}, done_cnt, 1);
            chk(done_at == e_done, "R8", {"done edge ", ctx}, done_at, e_done);
            chk(idle_bad == 0, "R9", {"idle after done ", ctx}, idle_bad, 0);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2718);
        build_plan();
        do_reset("first");
        run(0, 1'b1, "plain");

        // directed aborts: first edge, just past DLL reset write, on the done edge
        do_reset("pre-abort");
        run(1, 1'b0, "abort");
        do_reset("R10 after edge 1");
        run(0, 1'b1, "R10 restart a");

        do_reset("pre-abort");
        run(e_at[2] + 1, 1'b0, "abort");
        do_reset("R10 after DLL reset");
        run(0, 1'b1, "R10 restart b");

        do_reset("pre-abort");
        run(e_done, 1'b0, "abort");
        do_reset("R10 on done");
        run(0, 1'b1, "R10 restart c");

        for (int r = 0; r < 4; r++) begin
            int stop;
            stop = int'($urandom_range(e_done + 5, 1));
            do_reset("pre-abort");
            run(stop, 1'b0, "abort");
            do_reset($sformatf("R10 random stop %0d", stop));
            run(0, 1'b1, $sformatf("R10 random %0d", r));
        end
        summary();
        $finish;
    end
endmodule